// File: doc/BRIEF.md
# CAN message-center window decoder

This block sits between a processor's external data-space address bus and the message-center storage of two CAN controllers. It takes a 23-bit address and decides whether it falls inside the storage window that is currently selected. If it does, the block names the controller module, the message center and the byte inside that center. It also produces read and write strobes that storage can use directly. Decoding is purely combinational.

A map-select input chooses between two windows. The low window is a single 256-byte page at 0x00EE00. The high window is 512 bytes at 0x401000 and needs address bit 22. That bit is honoured only for CAN storage, and only while the processor runs in a 22-bit addressing mode. Each module has a software protect input that blocks writes to all of its storage. Each module also has a busy input, asserted while a CAN operation is in progress, that blocks writes to the identifier and format bytes. A write that is blocked sets a sticky violation flag for its module. Software clears that flag through a write-one-to-clear input.

Top module: `can_mc_decoder`

## Requirements
- R1: With mapSel=0, addresses 0x00EE00 to 0x00EEFF hit module 0. centerIdx is addr[7:4] and byteOff is addr[3:0]. All other addresses miss, including any address with bit 22 set. On a miss, modSel, centerIdx and byteOff are 0.
- R2: With mapSel=1 and wideMode=1, addresses 0x401000 to 0x4011FF hit. modSel is addr[8], centerIdx is addr[7:4] and byteOff is addr[3:0]. The low window does not hit while mapSel=1.
- R3: With mapSel=1 and wideMode=0, no address hits.
- R4: Inside either window, an access misses if its center index is 0 or its byte offset is 5, 6 or 7. Offsets 0 to 3 are the identifier bytes, offset 4 is the format byte, and offsets 8 to 15 are the data bytes.
- R5: rdStb equals rdReq AND hit. Protection, busy and violation state never affect it.
- R6: When protect[m]=1, no wrStb is produced for any byte of module m.
- R7: When busy[m]=1, writes to offsets 0 to 4 of module m produce no wrStb. Writes to data offsets 8 to 15 are still strobed, unless R6 blocks them.
- R8: A write that hits but is blocked by R6 or R7 sets viol[modSel] at the next clock edge. The flag stays set until it is cleared. A write that misses sets no flag.
- R9: violClr[m]=1 clears viol[m] at the next clock edge. If a new blocked write to module m arrives in the same cycle, the set wins.
- R10: While rst_n=0, viol is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the violation flags |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 23 | External data-space address, bit 22 being the CAN-only extra bit |
| mapSel | input | 1 | 0 selects the low window, 1 selects the high window |
| wideMode | input | 1 | 1 while the processor is in a 22-bit addressing mode |
| rdReq | input | 1 | Read request on the data bus |
| wrReq | input | 1 | Write request on the data bus |
| protect | input | 2 | Per-module software write protection |
| busy | input | 2 | Per-module CAN operation in progress |
| violClr | input | 2 | Per-module write-one-to-clear for viol |
| hit | output | 1 | Address decodes to valid message-center storage |
| modSel | output | 1 | Selected module |
| centerIdx | output | 4 | Message center index, 1 to 15 |
| byteOff | output | 4 | Byte offset inside the center |
| rdStb | output | 1 | Qualified read strobe |
| wrStb | output | 1 | Qualified write strobe |
| viol | output | 2 | Sticky per-module blocked-write flags |

## Verification
The decoder is driven with addresses on both sides of every window edge, under each combination of map-select and wide mode. This separates the correct window from its neighbours, the wrong window, and a lost bit 22. A full sweep of the low page checks every field against the reserved center and reserved offset rules. Writes are applied under protect only, busy only and both together, to identifier, format and data bytes. This separates the two blocking rules and confirms that each is tied to its own module. The violation flags are exercised with set, hold, clear, a missing write, and a set arriving in the same cycle as a clear.

// File: rtl/canwin_pkg.sv
package canwin_pkg;
  // Strobes passed from control to datapath
  typedef struct packed {
    logic rdStb;
    logic wrStb;
    logic violSet;
  } strobe_t;
endpackage

// File: rtl/canwin_dp.sv
module canwin_dp
  import canwin_pkg::*;
#(
  parameter int AW        = 23,
  parameter int NMOD      = 2,
  parameter int CW        = 4,
  parameter int OW        = 4,
  parameter int NCENTER   = 15,
  parameter int ARB_BYTES = 4,
  parameter int FMT_BYTES = 1,
  parameter int DATA_BYTES = 8,
  parameter logic [AW-1:0] LO_BASE = 23'h00EE00,
  parameter logic [AW-1:0] UP_BASE = 23'h401000,
  localparam int MODW = (NMOD > 1) ? $clog2(NMOD) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr,
  input  logic            mapSel,
  input  logic            wideMode,
  input  strobe_t         strb,
  input  logic [NMOD-1:0] violClr,
  output logic            hit,
  output logic [MODW-1:0] modSel,
  output logic [CW-1:0]   centerIdx,
  output logic [OW-1:0]   byteOff,
  output logic            isCtrlByte,
  output logic            rdStb,
  output logic            wrStb,
  output logic [NMOD-1:0] viol
);
  localparam int CTRL_BYTES = ARB_BYTES + FMT_BYTES;
  localparam int DATA_BASE  = (1 << OW) - DATA_BYTES;
  localparam int PAGE_LSB   = OW + CW;
  localparam int UP_LSB     = OW + CW + MODW;
  localparam logic [AW-PAGE_LSB-1:0] LO_TAG = LO_BASE[AW-1:PAGE_LSB];
  localparam logic [AW-UP_LSB-1:0]   UP_TAG = UP_BASE[AW-1:UP_LSB];

  logic          loMatch, upMatch, ctrOk, offOk;
  logic [CW-1:0] rawCtr;
  logic [OW-1:0] rawOff;

  always_comb begin
    loMatch = !mapSel && (addr[AW-1:PAGE_LSB] == LO_TAG);
    upMatch = mapSel && wideMode && (addr[AW-1:UP_LSB] == UP_TAG);
    rawCtr  = addr[PAGE_LSB-1:OW];
    rawOff  = addr[OW-1:0];
    ctrOk   = (rawCtr != '0) && (rawCtr <= CW'(NCENTER));
    offOk   = (rawOff < OW'(CTRL_BYTES)) || (rawOff >= OW'(DATA_BASE));
    hit     = (loMatch || upMatch) && ctrOk && offOk;
    modSel    = (hit && upMatch) ? addr[PAGE_LSB +: MODW] : '0;
    centerIdx = hit ? rawCtr : '0;
    byteOff   = hit ? rawOff : '0;
    isCtrlByte = rawOff < OW'(DATA_BASE);
    rdStb = strb.rdStb;
    wrStb = strb.wrStb;
  end

  generate
    for (genvar m = 0; m < NMOD; m++) begin : g_viol
      always_ff @(posedge clk) begin
        if (!rst_n)                                        viol[m] <= 1'b0;
        else if (strb.violSet && (modSel == MODW'(m)))     viol[m] <= 1'b1;
        else if (violClr[m])                               viol[m] <= 1'b0;
      end

      p_viol_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (viol[m] && !violClr[m]) |=> viol[m]);
      p_viol_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(viol[m]) |-> $past(violClr[m]));
    end
  endgenerate

  p_upper_needs_wide_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mapSel) |-> wideMode);
  p_miss_fields_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (centerIdx == '0 && byteOff == '0 && modSel == '0));
  p_hit_center_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (centerIdx != '0));
endmodule

// File: rtl/canwin_ctrl.sv
module canwin_ctrl
  import canwin_pkg::*;
#(
  parameter int NMOD = 2,
  localparam int MODW = (NMOD > 1) ? $clog2(NMOD) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rdReq,
  input  logic            wrReq,
  input  logic            hit,
  input  logic [MODW-1:0] modSel,
  input  logic            isCtrlByte,
  input  logic [NMOD-1:0] protect,
  input  logic [NMOD-1:0] busy,
  output strobe_t         strb
);
  logic blocked;

  always_comb begin
    blocked      = protect[modSel] || (busy[modSel] && isCtrlByte);
    strb.rdStb   = rdReq && hit;
    strb.wrStb   = wrReq && hit && !blocked;
    strb.violSet = wrReq && hit && blocked;
  end

  p_protect_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wrStb |-> !protect[modSel]);
  p_busy_blocks_ctrl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.wrStb && isCtrlByte) |-> !busy[modSel]);
  p_strobe_needs_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.rdStb || strb.wrStb) |-> hit);
endmodule

// File: rtl/can_mc_decoder.sv
module can_mc_decoder
  import canwin_pkg::*;
#(
  parameter int AW   = 23,
  parameter int NMOD = 2,
  parameter int CW   = 4,
  parameter int OW   = 4,
  localparam int MODW = (NMOD > 1) ? $clog2(NMOD) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr,
  input  logic            mapSel,
  input  logic            wideMode,
  input  logic            rdReq,
  input  logic            wrReq,
  input  logic [NMOD-1:0] protect,
  input  logic [NMOD-1:0] busy,
  input  logic [NMOD-1:0] violClr,
  output logic            hit,
  output logic [MODW-1:0] modSel,
  output logic [CW-1:0]   centerIdx,
  output logic [OW-1:0]   byteOff,
  output logic            rdStb,
  output logic            wrStb,
  output logic [NMOD-1:0] viol
);
  strobe_t strb;
  logic    isCtrlByte;

  canwin_dp #(.AW(AW), .NMOD(NMOD), .CW(CW), .OW(OW)) u_dp (
    .clk(clk), .rst_n(rst_n), .addr(addr), .mapSel(mapSel), .wideMode(wideMode),
    .strb(strb), .violClr(violClr), .hit(hit), .modSel(modSel),
    .centerIdx(centerIdx), .byteOff(byteOff), .isCtrlByte(isCtrlByte),
    .rdStb(rdStb), .wrStb(wrStb), .viol(viol)
  );

  canwin_ctrl #(.NMOD(NMOD)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rdReq(rdReq), .wrReq(wrReq), .hit(hit),
    .modSel(modSel), .isCtrlByte(isCtrlByte), .protect(protect), .busy(busy),
    .strb(strb)
  );
endmodule

// File: tb/test_can_mc_decoder.sv
module test_can_mc_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [22:0] addr;
  logic        mapSel, wideMode, rdReq, wrReq;
  logic [1:0]  protect, busy, violClr;
  logic        hit, modSel, rdStb, wrStb;
  logic [3:0]  centerIdx, byteOff;
  logic [1:0]  viol;
  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  can_mc_decoder i_can_mc_decoder (
    .clk(clk), .rst_n(rst_n), .addr(addr), .mapSel(mapSel), .wideMode(wideMode),
    .rdReq(rdReq), .wrReq(wrReq), .protect(protect), .busy(busy), .violClr(violClr),
    .hit(hit), .modSel(modSel), .centerIdx(centerIdx), .byteOff(byteOff),
    .rdStb(rdStb), .wrStb(wrStb), .viol(viol)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Drive after a falling edge and let the combinational outputs settle.
  task automatic drive(input logic [22:0] a, input logic ms, input logic wm,
                       input logic rd, input logic wr);
    @(negedge clk);
    addr = a; mapSel = ms; wideMode = wm; rdReq = rd; wrReq = wr;
    #1;
  endtask

  task automatic chkDec(input string tag, input logic eh, input logic em,
                        input logic [3:0] ec, input logic [3:0] eo);
    chk({tag, " hit"}, 32'(hit), 32'(eh));
    chk({tag, " mod"}, 32'(modSel), 32'(em));
    chk({tag, " ctr"}, 32'(centerIdx), 32'(ec));
    chk({tag, " off"}, 32'(byteOff), 32'(eo));
  endtask

  task automatic t_reset;
    rst_n = 1'b0; addr = '0; mapSel = 0; wideMode = 0; rdReq = 0; wrReq = 0;
    protect = 0; busy = 0; violClr = 0;
    repeat (3) @(posedge clk);
    #1 chk("R10 viol in reset", 32'(viol), 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_lower;
    drive(23'h00EE32, 0, 0, 0, 0); chkDec("R1 low mid", 1, 0, 3, 2);
    drive(23'h00EEFF, 0, 1, 0, 0); chkDec("R1 low top", 1, 0, 15, 15);
    drive(23'h00EDFF, 0, 0, 0, 0); chkDec("R1 below low", 0, 0, 0, 0);
    drive(23'h00EF10, 0, 0, 0, 0); chkDec("R1 above low", 0, 0, 0, 0);
    drive(23'h40EE32, 0, 0, 0, 0); chkDec("R1 bit22 set", 0, 0, 0, 0);
    for (int i = 0; i < 256; i++) begin
      logic [3:0] c, o;
      logic eh;
      c = 4'(i >> 4); o = 4'(i);
      eh = (c != 0) && (o < 5 || o > 7);
      drive(23'h00EE00 | 23'(i), 0, 0, 0, 0);
      chkDec("R4 low sweep", eh, 0, eh ? c : 4'd0, eh ? o : 4'd0);
    end
  endtask

  task automatic t_upper;
    drive(23'h401032, 1, 1, 0, 0); chkDec("R2 up mod0", 1, 0, 3, 2);
    drive(23'h401132, 1, 1, 0, 0); chkDec("R2 up mod1", 1, 1, 3, 2);
    drive(23'h4011FF, 1, 1, 0, 0); chkDec("R2 up top", 1, 1, 15, 15);
    drive(23'h401200, 1, 1, 0, 0); chkDec("R2 past up", 0, 0, 0, 0);
    drive(23'h401010, 1, 1, 0, 0); chkDec("R2 up first", 1, 0, 1, 0);
    drive(23'h001032, 1, 1, 0, 0); chkDec("R2 no bit22", 0, 0, 0, 0);
    drive(23'h00EE32, 1, 1, 0, 0); chkDec("R2 low while map1", 0, 0, 0, 0);
    drive(23'h401032, 0, 1, 0, 0); chkDec("R2 up while map0", 0, 0, 0, 0);
  endtask

  task automatic t_narrow;
    drive(23'h401032, 1, 0, 1, 1); chkDec("R3 narrow up", 0, 0, 0, 0);
    chk("R3 narrow rd", 32'(rdStb), 0);
    chk("R3 narrow wr", 32'(wrStb), 0);
    drive(23'h401132, 1, 0, 0, 0); chkDec("R3 narrow mod1", 0, 0, 0, 0);
  endtask

  task automatic t_reserved;
    drive(23'h401006, 1, 1, 0, 0); chkDec("R4 center0", 0, 0, 0, 0);
    drive(23'h401137, 1, 1, 0, 0); chkDec("R4 off7", 0, 0, 0, 0);
    drive(23'h401135, 1, 1, 0, 0); chkDec("R4 off5", 0, 0, 0, 0);
    drive(23'h401134, 1, 1, 0, 0); chkDec("R4 off4 fmt", 1, 1, 3, 4);
    drive(23'h401138, 1, 1, 0, 0); chkDec("R4 off8 data", 1, 1, 3, 8);
  endtask

  task automatic t_read;
    protect = 2'b11; busy = 2'b11;
    drive(23'h401130, 1, 1, 1, 0); chk("R5 read blocked state", 32'(rdStb), 1);
    chk("R5 read no wr", 32'(wrStb), 0);
    drive(23'h401200, 1, 1, 1, 0); chk("R5 read miss", 32'(rdStb), 0);
    @(posedge clk); #1 chk("R5 read sets no viol", 32'(viol), 0);
    protect = 0; busy = 0;
    drive(23'h00EE21, 0, 0, 1, 0); chk("R5 read free", 32'(rdStb), 1);
  endtask

  task automatic t_write_rules;
    drive(23'h401038, 1, 1, 0, 1); chk("R6 open write", 32'(wrStb), 1);
    protect = 2'b01;
    drive(23'h401038, 1, 1, 0, 1); chk("R6 prot mod0 data", 32'(wrStb), 0);
    drive(23'h401138, 1, 1, 0, 1); chk("R6 prot other mod", 32'(wrStb), 1);
    protect = 2'b00; busy = 2'b10;
    drive(23'h401130, 1, 1, 0, 1); chk("R7 busy arb", 32'(wrStb), 0);
    drive(23'h401134, 1, 1, 0, 1); chk("R7 busy fmt", 32'(wrStb), 0);
    drive(23'h40113F, 1, 1, 0, 1); chk("R7 busy data", 32'(wrStb), 1);
    drive(23'h401030, 1, 1, 0, 1); chk("R7 other mod arb", 32'(wrStb), 1);
    protect = 2'b10;
    drive(23'h40113F, 1, 1, 0, 1); chk("R6 prot+busy data", 32'(wrStb), 0);
    drive(23'h401200, 1, 1, 0, 1); chk("R8 miss write no stb", 32'(wrStb), 0);
    @(negedge clk); wrReq = 0; protect = 0; busy = 0;
    // Blocked writes above set both flags; clear them.
    violClr = 2'b11; @(posedge clk); #1 chk("R9 clear both", 32'(viol), 0);
    @(negedge clk); violClr = 0;
  endtask

  task automatic t_viol;
    protect = 2'b10;
    drive(23'h401200, 1, 1, 0, 1);
    @(posedge clk); #1 chk("R8 miss sets none", 32'(viol), 0);
    drive(23'h401138, 1, 1, 0, 1);
    @(posedge clk); #1 chk("R8 blocked sets mod1", 32'(viol), 2'b10);
    drive(23'h401138, 1, 1, 0, 0);
    repeat (2) @(posedge clk);
    #1 chk("R8 sticky", 32'(viol), 2'b10);
    protect = 0; busy = 2'b01;
    drive(23'h00EE12, 0, 0, 0, 1);
    @(posedge clk); #1 chk("R8 busy sets mod0", 32'(viol), 2'b11);
    @(negedge clk); wrReq = 0; busy = 0; violClr = 2'b01;
    @(posedge clk); #1 chk("R9 clear mod0 only", 32'(viol), 2'b10);
    @(negedge clk); violClr = 2'b10; protect = 2'b10;
    addr = 23'h401138; mapSel = 1; wideMode = 1; wrReq = 1;
    @(posedge clk); #1 chk("R9 set wins", 32'(viol), 2'b10);
    @(negedge clk); wrReq = 0; protect = 0;
    @(posedge clk); #1 chk("R9 clear mod1", 32'(viol), 0);
    @(negedge clk); violClr = 0;
    rst_n = 1'b0; protect = 2'b11;
    addr = 23'h401138; wrReq = 1;
    @(posedge clk); #1 chk("R10 reset holds viol", 32'(viol), 0);
    @(negedge clk); rst_n = 1'b1; wrReq = 0; protect = 0;
  endtask

  initial begin
    t_reset();
    t_lower();
    t_upper();
    t_narrow();
    t_reserved();
    t_read();
    t_write_rules();
    t_viol();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule